// File: doc/BRIEF.md
# Serial Configuration Port for a Dual Frequency Synthesizer

This block accepts configuration words from a host over a three-pin serial link: a serial clock, a data line and a latch strobe. The pins are sampled in the system clock domain. While the latch strobe is low, each rising edge of the serial clock shifts one data bit into a 24-bit shift register, most significant bit first. When the latch strobe rises, the three lowest bits of the shifted word name one of six configuration registers, and the remaining 21 bits are stored in that register. No other register changes.

The stored registers drive the settings of two synthesizers. The high-band synthesizer gets an integer value, a fraction, a modulus, a reference divide ratio, a charge-pump current code and a counter-reset bit. The low-band synthesizer gets swallow and main counter values, a reference divide ratio, a charge-pump current code and a counter-reset bit. A selectable source also drives a multiplexed status pin. That pin has an output enable so it can float.

Top module: `synth_cfg_port`

## Requirements
- R1: An active-low asynchronous reset clears every configuration register to zero. All setting outputs then read zero, and `mux_oe` is 0 (status pin floating).
- R2: Serial data is sampled on each rising edge of `ser_clk` while `ser_le` is low. The first bit sent ends up as word bit 23 and the last bit as word bit 0.
- R3: On a rising edge of `ser_le`, word bits 2..0 select the register (0 high-band N, 1 high-band modulus/reference, 2 high-band control, 3 low-band control, 4 low-band counters, 5 low-band reference) and word bits 23..3 are stored in it. With the default two sampling stages, the outputs change at the third rising `clk` edge after `ser_le` is driven high.
- R4: High-band fields by word bit: integer 22..15 and fraction 14..3 (code 0); reference divide 18..15 and modulus 14..3 (code 1); charge-pump code 6..4 (code 2).
- R5: Low-band fields by word bit: charge-pump code 6..4 (code 3); main counter 20..9 and swallow counter 8..3 (code 4); reference divide 17..3 (code 5).
- R6: A word whose control code is 6 or 7 is discarded, and every output keeps its value.
- R7: If `ser_le` rises after fewer than 24 serial clocks, the shift register's current contents are transferred. These contents are older bits shifted up by the new ones.
- R8: Serial clock edges seen while `ser_le` is high do not shift. A serial clock edge sampled in the same cycle as the latch edge is not taken, so the latched word excludes that bit.
- R9: A word sent as three 8-bit bursts within one low period of `ser_le`, with pauses between bursts, is latched exactly like 24 contiguous bits.
- R10: The status select field (word bits 9..7, code 2) sets the status pin: 0 floating (`mux_oe`=0); 1 drives high; 2 drives low; 3 drives `lock_rf`; 4 drives `lock_rf` AND `lock_if`; 5..7 drive low. For every value other than 0, `mux_oe` is 1.
- R11: Word bit 3 of code 2 drives `rf_cnt_rst`, and word bit 3 of code 3 drives `if_cnt_rst`. Each counter-reset output stays 1 until its register is rewritten with bit 3 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial shift clock from host |
| ser_data | input | 1 | Serial data from host |
| ser_le | input | 1 | Latch strobe from host |
| lock_rf | input | 1 | High-band lock indication |
| lock_if | input | 1 | Low-band lock indication |
| rf_int | output | 8 | High-band integer value |
| rf_frac | output | 12 | High-band fraction |
| rf_mod | output | 12 | High-band modulus |
| rf_rdiv | output | 4 | High-band reference divide |
| rf_cp | output | 3 | High-band charge-pump code |
| rf_cnt_rst | output | 1 | High-band counter reset |
| if_cp | output | 3 | Low-band charge-pump code |
| if_cnt_rst | output | 1 | Low-band counter reset |
| if_a | output | 6 | Low-band swallow counter |
| if_b | output | 12 | Low-band main counter |
| if_rdiv | output | 15 | Low-band reference divide |
| mux_out | output | 1 | Status pin value |
| mux_oe | output | 1 | Status pin output enable |

## Verification
The critical collision is a serial clock rising edge and a latch rising edge that land in the same sampled cycle. The bench provokes it by driving both pins high at the same instant after a full word has been shifted. An extra shift would turn the control code into 5, so the check is that the low-band reference divide keeps its earlier value while the intended control word is latched again. A second collision check toggles the serial clock while the strobe is high and then latches again. If those edges had shifted the register, the high-band integer would be overwritten. A behavioural reference model also compares every output on every clock.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

   // register codes carried in the low bits of every serial word
   typedef enum logic [2:0] {
      REG_RF_NF  = 3'd0,
      REG_RF_MR  = 3'd1,
      REG_RF_CTL = 3'd2,
      REG_IF_CTL = 3'd3,
      REG_IF_N   = 3'd4,
      REG_IF_R   = 3'd5
   } reg_code_e;

   // status pin sources
   typedef enum logic [2:0] {
      MUX_HIZ       = 3'd0,
      MUX_HIGH      = 3'd1,
      MUX_LOW       = 3'd2,
      MUX_LOCK_RF   = 3'd3,
      MUX_LOCK_BOTH = 3'd4
   } mux_sel_e;

   localparam int USED_REGS = 6;

   // field placement inside a stored payload (payload bit = word bit - 3)
   localparam int INT_LSB   = 12;
   localparam int INT_W     = 8;
   localparam int FRAC_LSB  = 0;
   localparam int FRAC_W    = 12;
   localparam int MOD_LSB   = 0;
   localparam int MOD_W     = 12;
   localparam int RRDIV_LSB = 12;
   localparam int RRDIV_W   = 4;
   localparam int CNT_BIT   = 0;
   localparam int CP_LSB    = 1;
   localparam int CP_W      = 3;
   localparam int MUX_LSB   = 4;
   localparam int MUX_W     = 3;
   localparam int A_LSB     = 0;
   localparam int A_W       = 6;
   localparam int B_LSB     = 6;
   localparam int B_W       = 12;
   localparam int IRDIV_LSB = 0;
   localparam int IRDIV_W   = 15;

   // widest field end inside any payload
   localparam int MIN_PAY_W = 20;

endpackage

// File: rtl/synth_cfg_shift.sv
module synth_cfg_shift #(
   parameter int WORD_W      = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              ser_le,
   output logic [WORD_W-1:0] word,
   output logic              load
);

   generate
      if (WORD_W < 4) begin : g_chk_w
         $error("WORD_W too small");
      end
      if (SYNC_STAGES < 0) begin : g_chk_s
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic clk_s, data_s, le_s;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign clk_s  = ser_clk;
         assign data_s = ser_data;
         assign le_s   = ser_le;
      end else begin : g_sync
         logic [2:0] stage [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) stage[i] <= '0;
            end else begin
               stage[0] <= {ser_clk, ser_data, ser_le};
               for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
            end
         end
         assign {clk_s, data_s, le_s} = stage[SYNC_STAGES-1];
      end
   endgenerate

   logic clk_q, le_q, clk_rise, take_bit;
   logic [WORD_W-1:0] sreg;

   assign clk_rise = clk_s & ~clk_q;
   assign take_bit = clk_rise & ~le_s;
   assign load     = le_s & ~le_q;
   assign word     = sreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_q <= 1'b0;
         le_q  <= 1'b0;
         sreg  <= '0;
      end else begin
         clk_q <= clk_s;
         le_q  <= le_s;
         if (take_bit) sreg <= {sreg[WORD_W-2:0], data_s};
      end
   end

   // R2: a sampled bit lands at the bottom of the shift register
   a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_rise && !le_s) |=> (sreg[0] == $past(data_s)));

   // R8: no shift without a serial clock edge while the strobe is low
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_rise || le_s) |=> $stable(sreg));

endmodule

// File: rtl/synth_cfg_bank.sv
module synth_cfg_bank #(
   parameter int WORD_W   = 24,
   parameter int ADDR_W   = 3,
   parameter int NUM_REGS = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [WORD_W-1:0]             word,
   input  logic                          load,
   output logic [NUM_REGS*(WORD_W-ADDR_W)-1:0] bank_q
);

   localparam int PAY_W = WORD_W - ADDR_W;

   generate
      if (NUM_REGS > (1 << ADDR_W)) begin : g_chk_n
         $error("NUM_REGS exceeds the address space");
      end
      if (PAY_W < 1) begin : g_chk_p
         $error("ADDR_W leaves no payload");
      end
   endgenerate

   logic [ADDR_W-1:0] code;
   logic [PAY_W-1:0]  payload;

   assign code    = word[ADDR_W-1:0];
   assign payload = word[WORD_W-1:ADDR_W];

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         logic [PAY_W-1:0] q;
         logic             hit;
         assign hit = load && (code == ADDR_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= payload;
         end
         assign bank_q[g*PAY_W +: PAY_W] = q;

         // R3: an addressed register takes the shifted payload
         a_r3_write: assert property (@(posedge clk) disable iff (!rst_n)
            (load && code == ADDR_W'(g)) |=> (bank_q[g*PAY_W +: PAY_W] == $past(word[WORD_W-1:ADDR_W])));

         // R6: a register not named by a latched word keeps its value
         a_r6_untouched: assert property (@(posedge clk) disable iff (!rst_n)
            (!load || code != ADDR_W'(g)) |=> $stable(bank_q[g*PAY_W +: PAY_W]));
      end
   endgenerate

endmodule

// File: rtl/synth_cfg_mux.sv
module synth_cfg_mux
   import synth_cfg_pkg::*;
#(
   parameter int SEL_W = 3
) (
   input  logic [SEL_W-1:0] sel,
   input  logic             lock_rf,
   input  logic             lock_if,
   output logic             pin,
   output logic             pin_oe
);

   generate
      if (SEL_W != 3) begin : g_chk
         $error("status select is three bits wide");
      end
   endgenerate

   always_comb begin
      pin_oe = 1'b1;
      pin    = 1'b0;
      case (mux_sel_e'(sel))
         MUX_HIZ:       pin_oe = 1'b0;
         MUX_HIGH:      pin    = 1'b1;
         MUX_LOW:       pin    = 1'b0;
         MUX_LOCK_RF:   pin    = lock_rf;
         MUX_LOCK_BOTH: pin    = lock_rf & lock_if;
         default:       pin    = 1'b0;
      endcase
   end

endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
   import synth_cfg_pkg::*;
#(
   parameter int WORD_W      = 24,
   parameter int ADDR_W      = 3,
   parameter int NUM_REGS    = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ser_clk,
   input  logic         ser_data,
   input  logic         ser_le,
   input  logic         lock_rf,
   input  logic         lock_if,
   output logic [7:0]   rf_int,
   output logic [11:0]  rf_frac,
   output logic [11:0]  rf_mod,
   output logic [3:0]   rf_rdiv,
   output logic [2:0]   rf_cp,
   output logic         rf_cnt_rst,
   output logic [2:0]   if_cp,
   output logic         if_cnt_rst,
   output logic [5:0]   if_a,
   output logic [11:0]  if_b,
   output logic [14:0]  if_rdiv,
   output logic         mux_out,
   output logic         mux_oe
);

   localparam int PAY_W = WORD_W - ADDR_W;

   generate
      if (NUM_REGS < USED_REGS) begin : g_chk_n
         $error("NUM_REGS too small for the decoded settings");
      end
      if (PAY_W < MIN_PAY_W) begin : g_chk_p
         $error("payload too narrow for the field layout");
      end
   endgenerate

   logic [WORD_W-1:0]         word;
   logic                      load;
   logic [NUM_REGS*PAY_W-1:0] bank_q;
   logic [PAY_W-1:0]          p [NUM_REGS];
   logic                      unused_bits;

   synth_cfg_shift #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .ser_clk  (ser_clk),
      .ser_data (ser_data),
      .ser_le   (ser_le),
      .word     (word),
      .load     (load)
   );

   synth_cfg_bank #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .word   (word),
      .load   (load),
      .bank_q (bank_q)
   );

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
         assign p[g] = bank_q[g*PAY_W +: PAY_W];
      end
   endgenerate

   assign unused_bits = ^bank_q;

   assign rf_int     = p[int'(REG_RF_NF)][INT_LSB +: INT_W];
   assign rf_frac    = p[int'(REG_RF_NF)][FRAC_LSB +: FRAC_W];
   assign rf_mod     = p[int'(REG_RF_MR)][MOD_LSB +: MOD_W];
   assign rf_rdiv    = p[int'(REG_RF_MR)][RRDIV_LSB +: RRDIV_W];
   assign rf_cp      = p[int'(REG_RF_CTL)][CP_LSB +: CP_W];
   assign rf_cnt_rst = p[int'(REG_RF_CTL)][CNT_BIT];
   assign if_cp      = p[int'(REG_IF_CTL)][CP_LSB +: CP_W];
   assign if_cnt_rst = p[int'(REG_IF_CTL)][CNT_BIT];
   assign if_a       = p[int'(REG_IF_N)][A_LSB +: A_W];
   assign if_b       = p[int'(REG_IF_N)][B_LSB +: B_W];
   assign if_rdiv    = p[int'(REG_IF_R)][IRDIV_LSB +: IRDIV_W];

   synth_cfg_mux #(.SEL_W(MUX_W)) u_mux (
      .sel     (p[int'(REG_RF_CTL)][MUX_LSB +: MUX_W]),
      .lock_rf (lock_rf),
      .lock_if (lock_if),
      .pin     (mux_out),
      .pin_oe  (mux_oe)
   );

   // R10: a zero status select floats the pin
   a_r10_float: assert property (@(posedge clk) disable iff (!rst_n)
      (p[int'(REG_RF_CTL)][MUX_LSB +: MUX_W] == 3'd0) |-> !mux_oe);

   // R10: the high source drives a one through an enabled pin
   a_r10_high: assert property (@(posedge clk) disable iff (!rst_n)
      (p[int'(REG_RF_CTL)][MUX_LSB +: MUX_W] == 3'd1) |-> (mux_oe && mux_out));

endmodule

// File: tb/synth_cfg_port_test.sv
module synth_cfg_port_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
   logic lock_rf = 1'b0, lock_if = 1'b0;
   logic [7:0]  rf_int;
   logic [11:0] rf_frac, rf_mod, if_b;
   logic [3:0]  rf_rdiv;
   logic [2:0]  rf_cp, if_cp;
   logic        rf_cnt_rst, if_cnt_rst, mux_out, mux_oe;
   logic [5:0]  if_a;
   logic [14:0] if_rdiv;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   synth_cfg_port uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
      .lock_rf(lock_rf), .lock_if(lock_if),
      .rf_int(rf_int), .rf_frac(rf_frac), .rf_mod(rf_mod), .rf_rdiv(rf_rdiv),
      .rf_cp(rf_cp), .rf_cnt_rst(rf_cnt_rst), .if_cp(if_cp), .if_cnt_rst(if_cnt_rst),
      .if_a(if_a), .if_b(if_b), .if_rdiv(if_rdiv), .mux_out(mux_out), .mux_oe(mux_oe)
   );

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [23:0] m_sr;
   logic [20:0] m_pay [6];
   logic [2:0]  m_pipe1, m_pipe2;   // {clk,data,le} after one and two samples
   logic        m_lastc, m_lastl;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sr = '0; m_pipe1 = '0; m_pipe2 = '0; m_lastc = 0; m_lastl = 0;
         for (int i = 0; i < 6; i++) m_pay[i] = '0;
      end else begin
         if (m_pipe2[0] && !m_lastl && int'(m_sr[2:0]) < 6)
            m_pay[int'(m_sr[2:0])] = m_sr[23:3];
         if (m_pipe2[2] && !m_lastc && !m_pipe2[0])
            m_sr = {m_sr[22:0], m_pipe2[1]};
         m_lastc = m_pipe2[2];
         m_lastl = m_pipe2[0];
         m_pipe2 = m_pipe1;
         m_pipe1 = {ser_clk, ser_data, ser_le};
      end
   end

   function automatic logic [1:0] exp_mux(logic [2:0] sel, logic lr, logic li);
      case (sel)
         3'd0: return 2'b00;
         3'd1: return 2'b11;
         3'd3: return {1'b1, lr};
         3'd4: return {1'b1, lr & li};
         default: return 2'b10;
      endcase
   endfunction

   always @(negedge clk) begin
      #1;
      if (!done) begin
         chk("R4", "rf_int",  rf_int,  m_pay[0][19:12]);
         chk("R4", "rf_frac", rf_frac, m_pay[0][11:0]);
         chk("R4", "rf_mod",  rf_mod,  m_pay[1][11:0]);
         chk("R4", "rf_rdiv", rf_rdiv, m_pay[1][15:12]);
         chk("R4", "rf_cp",   rf_cp,   m_pay[2][3:1]);
         chk("R11", "rf_cnt_rst", rf_cnt_rst, m_pay[2][0]);
         chk("R5", "if_cp",   if_cp,   m_pay[3][3:1]);
         chk("R11", "if_cnt_rst", if_cnt_rst, m_pay[3][0]);
         chk("R5", "if_a",    if_a,    m_pay[4][5:0]);
         chk("R5", "if_b",    if_b,    m_pay[4][17:6]);
         chk("R5", "if_rdiv", if_rdiv, m_pay[5][14:0]);
         chk("R10", "mux", {mux_oe, mux_out}, exp_mux(m_pay[2][6:4], lock_rf, lock_if));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put_bit(logic b);
      ser_data = b; ser_clk = 1'b0; tick(2);
      ser_clk = 1'b1; tick(2);
      ser_clk = 1'b0;
   endtask

   task automatic send(logic [23:0] w, int n);
      ser_le = 1'b0; tick(2);
      for (int i = n - 1; i >= 0; i--) put_bit(w[i]);
      tick(2);
      ser_le = 1'b1; tick(5);
   endtask

   task automatic send_bytes(logic [23:0] w);
      ser_le = 1'b0; tick(2);
      for (int k = 2; k >= 0; k--) begin
         for (int i = 7; i >= 0; i--) put_bit(w[k*8 + i]);
         tick(7);
      end
      ser_le = 1'b1; tick(5);
   endtask

   function automatic logic [23:0] w_nf(logic [7:0] i, logic [11:0] f);
      return {1'b0, i, f, 3'd0};
   endfunction
   function automatic logic [23:0] w_mr(logic [3:0] r, logic [11:0] m);
      return {5'd0, r, m, 3'd1};
   endfunction
   function automatic logic [23:0] w_rctl(logic [2:0] mx, logic [2:0] cp, logic rs);
      return {14'd0, mx, cp, rs, 3'd2};
   endfunction
   function automatic logic [23:0] w_ictl(logic [2:0] cp, logic rs);
      return {17'd0, cp, rs, 3'd3};
   endfunction
   function automatic logic [23:0] w_in(logic [11:0] b, logic [5:0] a);
      return {3'd0, b, a, 3'd4};
   endfunction
   function automatic logic [23:0] w_ir(logic [14:0] r);
      return {6'd0, r, 3'd5};
   endfunction

   // ---------------- watchdog ----------------
   initial begin
      #(10 * 150000);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   // ---------------- directed sequence ----------------
   initial begin
      tick(3);
      chk("R1", "rf_int at reset", rf_int, 0);
      chk("R1", "mux_oe at reset", mux_oe, 0);
      rst_n = 1'b1;
      tick(3);

      // R2 R3 R4: code 0, and latency of three clk edges
      ser_le = 1'b0; tick(2);
      for (int i = 23; i >= 0; i--) put_bit(w_nf(8'hA5, 12'h123)[i]);
      tick(2);
      ser_le = 1'b1;
      tick(2);
      chk("R3", "rf_int before third edge", rf_int, 0);
      tick(1);
      chk("R3", "rf_int after third edge", rf_int, 8'hA5);
      chk("R2", "rf_frac bit order", rf_frac, 12'h123);
      tick(3);

      send(w_mr(4'hB, 12'hABC), 24);
      chk("R4", "rf_rdiv", rf_rdiv, 4'hB);
      chk("R4", "rf_mod", rf_mod, 12'hABC);

      send(w_ir(15'h5555), 24);
      chk("R5", "if_rdiv", if_rdiv, 15'h5555);

      // R9: three bursts in one strobe window
      send_bytes(w_in(12'h9C3, 6'h2A));
      chk("R9", "if_b from bursts", if_b, 12'h9C3);
      chk("R9", "if_a from bursts", if_a, 6'h2A);

      // R6: unused codes leave everything alone
      send({21'h1FFFFF, 3'd6}, 24);
      send({21'h1FFFFF, 3'd7}, 24);
      chk("R6", "rf_int kept", rf_int, 8'hA5);
      chk("R6", "if_rdiv kept", if_rdiv, 15'h5555);
      chk("R6", "if_b kept", if_b, 12'h9C3);

      // R7: short word transfers shifted contents
      send(w_mr(4'h3, 12'h0FF), 24);
      send({16'h0, 8'h5B}, 8);
      chk("R7", "if_cnt_rst from short word", if_cnt_rst, 1);
      chk("R7", "if_cp from short word", if_cp, 3'd5);
      chk("R7", "rf_mod untouched", rf_mod, 12'h0FF);

      // R8: same-cycle serial edge and latch edge
      send(w_rctl(3'd1, 3'd2, 1'b1), 24);
      ser_le = 1'b0; ser_data = 1'b1; ser_clk = 1'b0; tick(3);
      ser_clk = 1'b1; ser_le = 1'b1; tick(5);
      ser_clk = 1'b0;
      chk("R8", "if_rdiv unchanged by collision", if_rdiv, 15'h5555);
      chk("R8", "rf_cp relatched", rf_cp, 3'd2);
      // R8: serial edges while strobe high
      ser_data = 1'b0;
      for (int i = 0; i < 5; i++) begin
         ser_clk = 1'b1; tick(2); ser_clk = 1'b0; tick(2);
      end
      ser_le = 1'b0; tick(3); ser_le = 1'b1; tick(5);
      chk("R8", "rf_int unchanged after high-strobe clocks", rf_int, 8'hA5);

      // R11: counter reset bits
      chk("R11", "rf_cnt_rst set", rf_cnt_rst, 1);
      send(w_rctl(3'd1, 3'd2, 1'b0), 24);
      chk("R11", "rf_cnt_rst cleared", rf_cnt_rst, 0);
      send(w_ictl(3'd6, 1'b0), 24);
      chk("R11", "if_cnt_rst cleared", if_cnt_rst, 0);

      // R10: every status source under every lock pattern
      for (int s = 0; s < 8; s++) begin
         send(w_rctl(3'(s), 3'(s), 1'b0), 24);
         for (int l = 0; l < 4; l++) begin
            lock_rf = l[0]; lock_if = l[1];
            tick(2);
            chk("R10", "status pin", {mux_oe, mux_out}, exp_mux(3'(s), l[0], l[1]));
         end
      end

      // R1: reset in the middle of operation
      rst_n = 1'b0; tick(2);
      chk("R1", "rf_int cleared", rf_int, 0);
      chk("R1", "if_b cleared", if_b, 0);
      chk("R1", "mux_oe cleared", mux_oe, 0);
      rst_n = 1'b1; tick(3);

      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule